// File: doc/BRIEF.md
# Sector Block Transfer Scheduler

This block keeps a small set of pending transfer requests, one per fixed-size slice of a 64 KB aligned memory window, and hands them one at a time to an external byte mover. Each of the sixteen request bits stands for a 4 KB slice. Software can raise requests but never withdraw them. The scheduler always serves the highest-numbered pending slice first, presents that slice's start address while the transfer runs, and waits for the mover to report completion.

A completion drops the finished request bit and raises a sticky completion flag for the interrupt controller. Software acknowledges the flag with any register write, including a write of all zeros. A separate transfer-enable input gates everything. While it is low the request set is held empty, writes to it are discarded, and any transfer in flight is dropped at once.

Top module: `blkdma_sched`

## Requirements
- R1: While a transfer is active, `blk_addr` equals `win_base` with its low 16 bits forced to zero, plus the served slice index times 0x1000. The index is 4 bits, at address bits 15:12.
- R2: With `xfer_en` high, a write ORs `wr_data` into `pend_bits` at the next clock edge. Zero bits in the written value leave the matching pending bits unchanged, and a set bit is never cleared by a write.
- R3: When idle with pending bits present, the scheduler starts the highest-numbered pending slice at the next edge, with `req_valid` high. Slice 15 is therefore served before 14, and so on down to slice 0.
- R4: On an edge where `blk_done` is high during an active transfer, the served slice's bit is cleared, `irq` becomes 1 and `req_valid` falls.
- R5: Any write clears `irq` at the next edge, whatever the data and whatever the state of `xfer_en`. If a completion lands on the same edge, `irq` is set instead.
- R6: While `xfer_en` is low, `pend_bits` reads zero after the next edge, writes to it have no effect, and an active transfer is aborted (`req_valid` low) without raising `irq`.
- R7: Requests set during an active transfer do not preempt it. `blk_addr` holds until completion, and the newly set bit is considered only after that.
- R8: `blk_done` is ignored while no transfer is active. It changes neither `pend_bits` nor `irq`.
- R9: After reset, `pend_bits` is 0, and `req_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_en | input | 1 | Transfer enable from configuration |
| win_base | input | AW (32) | Window base address; the low 16 bits are ignored |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | NBLK (16) | Write data; ones set request bits |
| pend_bits | output | NBLK (16) | Current pending request set (read value) |
| req_valid | output | 1 | A slice transfer is active |
| blk_addr | output | AW (32) | Start address of the active slice |
| blk_done | input | 1 | Mover reports the active slice finished |
| irq | output | 1 | Sticky slice-completion flag |

## Verification
All results register on the edge that samples their cause. A write shows in `pend_bits` and `irq` one edge later. A request raised in idle shows in `req_valid` and `blk_addr` two edges after the write. A completion clears the served bit, raises `irq` and drops `req_valid` on its own edge, and the next slice starts one edge after that. The bench drives inputs and samples outputs on the falling edge, so every check looks at the state after exactly the number of rising edges listed. A cycle-level reference model in the bench, written as a top-down bit search rather than a one-hot mask, predicts all four outputs on every cycle of the random phase.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  // Start address of slice idx: window base with its low win_shift bits
  // cleared, plus idx scaled by the slice size.
  function automatic logic [63:0] slice_addr(input logic [63:0] base,
                                             input int unsigned idx,
                                             input int unsigned blk_shift,
                                             input int unsigned win_shift);
    logic [63:0] win;
    logic [63:0] off;
    win = (base >> win_shift) << win_shift;
    off = 64'(idx) << blk_shift;
    return win | off;
  endfunction

  // Pending-set update: set bits OR in, the completion mask clears.
  function automatic logic [63:0] pend_next(input logic [63:0] cur,
                                            input logic [63:0] set_mask,
                                            input logic [63:0] clr_mask);
    return (cur | set_mask) & ~clr_mask;
  endfunction

endpackage

// File: rtl/blkdma_pend_reg.sv
module blkdma_pend_reg #(
  parameter int NBLK = 16,
  localparam int IDXW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            wr_en,
  input  logic [NBLK-1:0] wr_data,
  input  logic            clr_en,
  input  logic [IDXW-1:0] clr_idx,
  output logic [NBLK-1:0] pend
);
  import blkdma_pkg::*;

  logic [NBLK-1:0] set_mask;
  logic [NBLK-1:0] clr_mask;
  logic [NBLK-1:0] nxt;

  always_comb begin
    set_mask = wr_en ? wr_data : '0;
    clr_mask = clr_en ? (NBLK'(1) << clr_idx) : '0;
    nxt      = NBLK'(pend_next(64'(pend), 64'(set_mask), 64'(clr_mask)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pend <= '0;
    else if (!en) pend <= '0;
    else          pend <= nxt;
  end
endmodule

// File: rtl/blkdma_prio.sv
module blkdma_prio #(
  parameter int NBLK = 16,
  localparam int IDXW = $clog2(NBLK)
) (
  input  logic [NBLK-1:0] req,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  logic [NBLK-1:0] grant;

  for (genvar i = 0; i < NBLK; i++) begin : g_grant
    if (i == NBLK - 1) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_low
      assign grant[i] = req[i] & ~(|req[NBLK-1:i+1]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NBLK; i++) begin
      idx = idx | (grant[i] ? IDXW'(i) : '0);
    end
    any = |req;
  end
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq #(
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            any_pend,
  input  logic [IDXW-1:0] pick_idx,
  input  logic            blk_done,
  output logic            busy,
  output logic [IDXW-1:0] cur_idx,
  output logic            done_evt
);
  import blkdma_pkg::*;

  seq_state_e st;

  assign busy     = (st == SEQ_BUSY);
  assign done_evt = busy & blk_done & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      cur_idx <= '0;
    end else if (!en) begin
      st <= SEQ_IDLE;
    end else begin
      case (st)
        SEQ_IDLE: if (any_pend) begin
          st      <= SEQ_BUSY;
          cur_idx <= pick_idx;
        end
        SEQ_BUSY: if (blk_done) st <= SEQ_IDLE;
        default:  st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkdma_irq.sv
module blkdma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_evt,
  input  logic done_evt,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (done_evt) irq <= 1'b1;
    else if (ack_evt)  irq <= 1'b0;
  end
endmodule

// File: rtl/blkdma_sched.sv
module blkdma_sched #(
  parameter int NBLK      = 16,
  parameter int BLK_SHIFT = 12,
  parameter int AW        = 32,
  localparam int IDXW      = $clog2(NBLK),
  localparam int WIN_SHIFT = BLK_SHIFT + IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_en,
  input  logic [AW-1:0]   win_base,
  input  logic            wr_en,
  input  logic [NBLK-1:0] wr_data,
  output logic [NBLK-1:0] pend_bits,
  output logic            req_valid,
  output logic [AW-1:0]   blk_addr,
  input  logic            blk_done,
  output logic            irq
);
  import blkdma_pkg::*;

  logic            any_pend;
  logic [IDXW-1:0] pick_idx;
  logic            busy;
  logic [IDXW-1:0] cur_idx;
  logic            done_evt;
  logic            ack_evt;

  assign ack_evt = wr_en;

  blkdma_pend_reg #(.NBLK(NBLK)) u_pend (
    .clk(clk), .rst_n(rst_n), .en(xfer_en),
    .wr_en(wr_en), .wr_data(wr_data),
    .clr_en(done_evt), .clr_idx(cur_idx),
    .pend(pend_bits)
  );

  blkdma_prio #(.NBLK(NBLK)) u_prio (
    .req(pend_bits), .any(any_pend), .idx(pick_idx)
  );

  blkdma_seq #(.IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(xfer_en),
    .any_pend(any_pend), .pick_idx(pick_idx), .blk_done(blk_done),
    .busy(busy), .cur_idx(cur_idx), .done_evt(done_evt)
  );

  blkdma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ack_evt(ack_evt),
    .done_evt(done_evt), .irq(irq)
  );

  assign req_valid = busy;
  assign blk_addr  = AW'(slice_addr(64'(win_base), int'(cur_idx),
                                    BLK_SHIFT, WIN_SHIFT));
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int NBLK      = 16,
  parameter int BLK_SHIFT = 12,
  parameter int AW        = 32,
  localparam int IDXW = $clog2(NBLK)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_en,
  input logic            wr_en,
  input logic [NBLK-1:0] pend_bits,
  input logic            busy,
  input logic [IDXW-1:0] cur_idx,
  input logic            done_evt,
  input logic            blk_done,
  input logic [AW-1:0]   blk_addr,
  input logic            irq
);
  AST_ADDR_SLICE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (blk_addr[BLK_SHIFT-1:0] == '0)); // R1
  AST_NO_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !done_evt) |=> ((pend_bits & $past(pend_bits)) == $past(pend_bits))); // R2
  AST_SERVED_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pend_bits[cur_idx]); // R3
  AST_HIGHEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (($past(pend_bits) >> cur_idx) == NBLK'(1))); // R3
  AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq && !busy)); // R4
  AST_DONE_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !pend_bits[$past(cur_idx)]); // R4
  AST_WRITE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !done_evt) |=> !irq); // R5
  AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> (pend_bits == '0 && !busy)); // R6
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_done && xfer_en) |=> (busy && $stable(cur_idx))); // R7
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en && xfer_en) |=> ((irq == $past(irq)) && ((pend_bits) == $past(pend_bits)))); // R8
endmodule

bind blkdma_sched blkdma_chk #(.NBLK(NBLK), .BLK_SHIFT(BLK_SHIFT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .wr_en(wr_en),
  .pend_bits(pend_bits), .busy(busy), .cur_idx(cur_idx),
  .done_evt(done_evt), .blk_done(blk_done), .blk_addr(blk_addr), .irq(irq)
);

// File: tb/sim_blkdma_sched.sv
module sim_blkdma_sched;
  localparam int NBLK = 16;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            xfer_en = 1'b0;
  logic [AW-1:0]   win_base = 32'h1234_5678;
  logic            wr_en = 1'b0;
  logic [NBLK-1:0] wr_data = '0;
  logic [NBLK-1:0] pend_bits;
  logic            req_valid;
  logic [AW-1:0]   blk_addr;
  logic            blk_done = 1'b0;
  logic            irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  blkdma_sched u0 (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .win_base(win_base),
    .wr_en(wr_en), .wr_data(wr_data), .pend_bits(pend_bits),
    .req_valid(req_valid), .blk_addr(blk_addr), .blk_done(blk_done), .irq(irq)
  );

  // Reference model, built from the requirements.
  logic [NBLK-1:0] m_pend;
  logic            m_busy;
  int              m_idx;
  logic            m_irq;

  function automatic int top_bit(input logic [NBLK-1:0] v);
    for (int i = NBLK - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int idx);
    return {win_base[AW-1:16], 16'h0} + AW'(idx * 4096);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_pend <= '0; m_busy <= 1'b0; m_idx <= 0; m_irq <= 1'b0;
    end else begin
      logic fin;
      logic [NBLK-1:0] p;
      fin = m_busy && blk_done && xfer_en;
      p = m_pend;
      if (wr_en) p = p | wr_data;
      if (fin) p[m_idx] = 1'b0;
      m_pend <= xfer_en ? p : '0;
      if (fin) m_irq <= 1'b1;
      else if (wr_en) m_irq <= 1'b0;
      if (!xfer_en) m_busy <= 1'b0;
      else if (m_busy) begin
        if (blk_done) m_busy <= 1'b0;
      end else if (m_pend != '0) begin
        m_busy <= 1'b1;
        m_idx  <= top_bit(m_pend);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 pend", 32'(pend_bits), 0);
    check("R9 req_valid", 32'(req_valid), 0);
    check("R9 irq", 32'(irq), 0);
    rst_n = 1'b1; xfer_en = 1'b1;
    tick();
    // R2: write sets bits 15 and 0
    wr_en = 1'b1; wr_data = 16'h8001;
    tick();
    wr_en = 1'b0;
    check("R2 pend after set", 32'(pend_bits), 32'h8001);
    tick();
    // R3 / R1: highest first, address of slice 15
    check("R3 req after pick", 32'(req_valid), 1);
    check("R1 addr slice15", blk_addr, 32'h1234_F000);
    // R7: late request does not preempt
    wr_en = 1'b1; wr_data = 16'h0100;
    tick();
    wr_en = 1'b0;
    check("R7 pend merged", 32'(pend_bits), 32'h8101);
    check("R7 addr held", blk_addr, 32'h1234_F000);
    // R4: completion
    blk_done = 1'b1;
    tick();
    blk_done = 1'b0;
    check("R4 bit cleared", 32'(pend_bits), 32'h0101);
    check("R4 irq set", 32'(irq), 1);
    check("R4 req dropped", 32'(req_valid), 0);
    tick();
    check("R7 next is slice8", blk_addr, 32'h1234_8000);
    // R5: zero write only acknowledges
    wr_en = 1'b1; wr_data = 16'h0000;
    tick();
    wr_en = 1'b0;
    check("R5 irq acked", 32'(irq), 0);
    check("R5 pend unchanged", 32'(pend_bits), 32'h0101);
    blk_done = 1'b1; tick(); blk_done = 1'b0;
    tick();
    check("R3 slice0 last", blk_addr, 32'h1234_0000);
    blk_done = 1'b1; tick(); blk_done = 1'b0;
    check("R4 all served", 32'(pend_bits), 0);
    wr_en = 1'b1; wr_data = '0; tick(); wr_en = 1'b0;
    // R8: done while idle
    blk_done = 1'b1; tick(); blk_done = 1'b0;
    check("R8 irq unchanged", 32'(irq), 0);
    check("R8 pend unchanged", 32'(pend_bits), 0);
    // R6: abort mid-transfer
    wr_en = 1'b1; wr_data = 16'h0030; tick(); wr_en = 1'b0;
    tick();
    check("R3 slice5 first", blk_addr, 32'h1234_5000);
    blk_done = 1'b1; tick(); blk_done = 1'b0;
    tick();
    xfer_en = 1'b0;
    tick();
    check("R6 pend cleared", 32'(pend_bits), 0);
    check("R6 req aborted", 32'(req_valid), 0);
    wr_en = 1'b1; wr_data = 16'h00FF; tick(); wr_en = 1'b0;
    check("R6 write ignored", 32'(pend_bits), 0);
    check("R5 ack while disabled", 32'(irq), 0);
    xfer_en = 1'b1;
    tick();
    // Random phase against the model
    for (int k = 0; k < 4000; k++) begin
      check("R2 pend model", 32'(pend_bits), 32'(m_pend));
      check("R3 req model", 32'(req_valid), 32'(m_busy));
      if (m_busy) check("R1 addr model", blk_addr, exp_addr(m_idx));
      check("R4 irq model", 32'(irq), 32'(m_irq));
      xfer_en  = ($urandom % 80) != 0;
      wr_en    = ($urandom % 5) == 0;
      wr_data  = NBLK'($urandom & $urandom & $urandom);
      blk_done = m_busy ? (($urandom % 3) == 0) : (($urandom % 8) == 0);
      if (k % 1000 == 999) win_base = $urandom;
      tick();
    end
    finish_run();
  end
endmodule